// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Fault Detection

This unit divides a double-width dividend by a single-width divisor for an accumulator-style integer datapath. Four operand sizes are selectable per operation (an eighth, a quarter, half or all of the parameter width `W`), each in unsigned or two's-complement signed form. The dividend is built from a high and a low register value, or, for the smallest size, from the low register alone. The unit produces a quotient and a remainder. It flags a divide fault when the divisor is zero or the quotient cannot be represented in the operand size.

A caller raises `start` for one cycle while `busy` is low, with the size code, the signed select, both dividend halves and the divisor. The unit converts the operands to magnitudes and rejects impossible divisions at once. Otherwise it runs one restoring step per quotient bit. It then restores the signs and range-checks the result. `done` pulses for one cycle and `fault` is valid with it. Results land in registered outputs, which keep their old values when a fault is reported. Register writeback, exception handling and condition flags are left to the surrounding datapath.

Top module: `idiv_unit`

## Requirements
- R1: Size code 2'b00 (n = W/8) takes the 2n-bit dividend from `dvd_lo[2n-1:0]` and ignores `dvd_hi`. `quotient[n-1:0]` holds the quotient and `quotient[2n-1:n]` holds the remainder. All other bits of `quotient` and all bits of `remainder` are zero.
- R2: Size codes 2'b01, 2'b10 and 2'b11 select n = W/4, W/2 and W. The dividend is `{dvd_hi[n-1:0], dvd_lo[n-1:0]}`. The quotient appears on `quotient` and the remainder on `remainder`, each zero above bit n-1.
- R3: A divisor whose low n bits are all zero reports `fault` together with `done`, and `quotient` and `remainder` keep their previous values. The same hold applies to every faulting operation.
- R4: With `sgn` = 0, a quotient of 2^n or more faults, and a quotient of 2^n - 1 is delivered.
- R5: With `sgn` = 1, both operands are read as two's complement in their own widths (2n and n bits). The quotient is truncated toward zero and a non-zero remainder takes the sign of the dividend. Both are returned as n-bit patterns.
- R6: In signed mode a quotient of -2^(n-1) is delivered and a quotient of +2^(n-1) faults. An example is the most negative dividend divided by -1.
- R7: `done` is high for exactly one cycle, n+1 cycles after the clock edge that accepts `start`. When the divisor is zero or the quotient magnitude is 2^n or more, it comes 1 cycle after that edge. `fault` is high only together with `done`.
- R8: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance up to the edge that raises `done`. Any `start` or input change while busy has no effect on the result, and a `start` in the `done` cycle is accepted.
- R9: A synchronous active-high `rst` drives `busy`, `done` and `fault` low and clears `quotient` and `remainder` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division (sampled while not busy) |
| size | input | 2 | Operand size code: 00 W/8, 01 W/4, 10 W/2, 11 W |
| sgn | input | 1 | 1 selects signed division |
| dvd_hi | input | W | Upper dividend half (unused for size 00) |
| dvd_lo | input | W | Lower dividend half |
| divisor | input | W | Divisor, low n bits used |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Divide fault, valid with done |
| quotient | output | W | Quotient (size 00: packed quotient and remainder) |
| remainder | output | W | Remainder (size 00: zero) |

## Verification
The bench builds the unit with the default `W` = 64, which gives operand sizes of 8, 16, 32 and 64 bits in one elaboration. The 64-bit size needs a 128-bit dividend, its two's-complement negation and a 64-step loop. At this width the most negative 128-bit dividend divided by -1, and quotients exactly at 2^n - 1, -2^(n-1) and 2^(n-1), are all reachable. Every size is compared against a wide-integer reference model computed in the bench, including the timing of early and late faults.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_W = 2'b01,
    SZ_D = 2'b10,
    SZ_Q = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } state_e;

  // operand width selected by a size code for a datapath of width w
  function automatic int op_bits(size_e s, int w);
    case (s)
      SZ_B:    return w / 8;
      SZ_W:    return w / 4;
      SZ_D:    return w / 2;
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/idiv_prep.sv
// Operand extraction, magnitude conversion and up-front fault screening.
module idiv_prep
  import idiv_pkg::*;
#(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  size_e          sz,
  input  logic           sgn,
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   lo,
  input  logic [W-1:0]   dv,
  output logic [W-1:0]   rem0,
  output logic [W-1:0]   sh0,
  output logic [W-1:0]   dmag,
  output logic [CW-1:0]  nbits,
  output logic           neg_n,
  output logic           neg_d,
  output logic           zero_d,
  output logic           early_ovf
);
  localparam int N0 = W / 8;
  localparam int N1 = W / 4;
  localparam int N2 = W / 2;
  localparam int W2 = 2 * W;

  int            n;
  logic [W2-1:0] dvd;
  logic [W2-1:0] mask2;
  logic [W2-1:0] mag;
  logic [W-1:0]  maskn;
  logic [W-1:0]  lo_m;
  logic [W-1:0]  dv_m;

  always_comb begin
    n     = op_bits(sz, W);
    maskn = {W{1'b1}} >> (W - n);
    mask2 = {W2{1'b1}} >> (W2 - 2 * n);
    case (sz)
      SZ_B:    dvd = {{(W2 - 2 * N0){1'b0}}, lo[2*N0-1:0]};
      SZ_W:    dvd = {{(W2 - 2 * N1){1'b0}}, hi[N1-1:0], lo[N1-1:0]};
      SZ_D:    dvd = {{(W2 - 2 * N2){1'b0}}, hi[N2-1:0], lo[N2-1:0]};
      default: dvd = {hi, lo};
    endcase
    // sign bit of the 2n-bit dividend: top bit inside mask2
    neg_n = sgn & (|(dvd & (mask2 ^ (mask2 >> 1))));
    mag   = neg_n ? ((-dvd) & mask2) : dvd;
    rem0  = W'(mag >> n);
    lo_m  = mag[W-1:0] & maskn;
    sh0   = lo_m << (W - n);
    dv_m  = dv & maskn;
    neg_d = sgn & (|(dv_m & (maskn ^ (maskn >> 1))));
    dmag  = neg_d ? ((-dv_m) & maskn) : dv_m;
    zero_d    = (dv_m == '0);
    // upper half not below divisor: magnitude quotient needs > n bits
    early_ovf = (rem0 >= dmag);
    nbits     = CW'(n);
  end

endmodule

// File: rtl/idiv_step.sv
// One restoring iteration: shift in next dividend bit, trial subtract.
module idiv_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] sh,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] rem_n,
  output logic [W-1:0] sh_n
);
  logic [W:0] trial;
  logic [W:0] diff;
  logic       take;

  always_comb begin
    trial = {rem, sh[W-1]};
    diff  = trial - {1'b0, dvs};
    take  = (trial >= {1'b0, dvs});
    rem_n = take ? diff[W-1:0] : trial[W-1:0];
    sh_n  = {sh[W-2:0], take};
  end

endmodule

// File: rtl/idiv_fix.sv
// Sign restoration, signed range check and result packing.
module idiv_fix
  import idiv_pkg::*;
#(
  parameter int W = 64
) (
  input  size_e        sz,
  input  logic         sgn,
  input  logic         neg_n,
  input  logic         neg_d,
  input  logic [W-1:0] qmag,
  input  logic [W-1:0] rmag,
  output logic [W-1:0] q_out,
  output logic [W-1:0] r_out,
  output logic         ovf
);
  localparam int N0 = W / 8;

  int           n;
  logic [W-1:0] maskn;
  logic [W-1:0] lim;
  logic [W-1:0] q_s;
  logic [W-1:0] r_s;
  logic         differ;

  always_comb begin
    n      = op_bits(sz, W);
    maskn  = {W{1'b1}} >> (W - n);
    lim    = {{(W - 1){1'b0}}, 1'b1} << (n - 1);
    differ = neg_n ^ neg_d;
    q_s    = differ ? ((-qmag) & maskn) : qmag;
    r_s    = neg_n ? ((-rmag) & maskn) : rmag;
    // negative results reach one step further than positive ones
    ovf    = sgn & (differ ? (qmag > lim) : (qmag >= lim));
    q_out  = q_s;
    r_out  = r_s;
    if (sz == SZ_B) begin
      q_out = '0;
      q_out[2*N0-1:0] = {r_s[N0-1:0], q_s[N0-1:0]};
      r_out = '0;
    end
  end

endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
  import idiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   size,
  input  logic         sgn,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         fault,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W + 1);

  state_e        st;
  size_e         sz_in;
  size_e         sz_q;
  logic          sgn_q, negn_q, negd_q, pf_q;
  logic [W-1:0]  rem_q, sh_q, dvs_q;
  logic [CW-1:0] cnt_q;

  logic [W-1:0]  rem0, sh0, dmag, rem_nx, sh_nx, q_out, r_out;
  logic [CW-1:0] nbits;
  logic          neg_n, neg_d, zero_d, early_ovf, ovf;

  assign sz_in = size_e'(size);
  assign busy  = (st != ST_IDLE);

  idiv_prep #(.W(W), .CW(CW)) u_prep (
    .sz(sz_in), .sgn(sgn), .hi(dvd_hi), .lo(dvd_lo), .dv(divisor),
    .rem0(rem0), .sh0(sh0), .dmag(dmag), .nbits(nbits),
    .neg_n(neg_n), .neg_d(neg_d), .zero_d(zero_d), .early_ovf(early_ovf)
  );

  idiv_step #(.W(W)) u_step (
    .rem(rem_q), .sh(sh_q), .dvs(dvs_q), .rem_n(rem_nx), .sh_n(sh_nx)
  );

  idiv_fix #(.W(W)) u_fix (
    .sz(sz_q), .sgn(sgn_q), .neg_n(negn_q), .neg_d(negd_q),
    .qmag(sh_q), .rmag(rem_q), .q_out(q_out), .r_out(r_out), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      fault     <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      rem_q     <= '0;
      sh_q      <= '0;
      dvs_q     <= '0;
      cnt_q     <= '0;
      sz_q      <= SZ_B;
      sgn_q     <= 1'b0;
      negn_q    <= 1'b0;
      negd_q    <= 1'b0;
      pf_q      <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            rem_q  <= rem0;
            sh_q   <= sh0;
            dvs_q  <= dmag;
            cnt_q  <= nbits;
            sz_q   <= sz_in;
            sgn_q  <= sgn;
            negn_q <= neg_n;
            negd_q <= neg_d;
            pf_q   <= zero_d | early_ovf;
            st     <= (zero_d | early_ovf) ? ST_FIX : ST_RUN;
          end
        end
        ST_RUN: begin
          rem_q <= rem_nx;
          sh_q  <= sh_nx;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) st <= ST_FIX;
        end
        default: begin
          done  <= 1'b1;
          fault <= pf_q | ovf;
          if (!(pf_q | ovf)) begin
            quotient  <= q_out;
            remainder <= r_out;
          end
          st <= ST_IDLE;
        end
      endcase
    end
  end

  // R9: reset leaves the unit quiet
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!busy && !done && !fault && quotient == '0 && remainder == '0));

  // R7: completion is a single-cycle pulse, fault only alongside it
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_fault_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    fault |-> done);

  // R8: acceptance raises busy; captured divisor frozen while busy
  p_busy_after_start_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  p_inputs_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dvs_q));

  // R3: zero divisor faults one cycle after acceptance; outputs hold
  p_zero_fault_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=> ##1 (done && fault));
  p_fault_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> ($stable(quotient) && $stable(remainder)));

  // R4: the early screen keeps the partial remainder below the divisor
  p_partial_below_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> (rem_q < dvs_q));

endmodule

// File: tb/test_idiv_unit.sv
module test_idiv_unit;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   size = 2'b00;
  logic         sgn = 1'b0;
  logic [W-1:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic         busy, done, fault;
  logic [W-1:0] quotient, remainder;

  int nchk = 0, nbad = 0, cyc = 0;
  logic [63:0] last_q = '0, last_r = '0;

  always #4 clk = ~clk;

  idiv_unit #(.W(W)) i_idiv_unit (
    .clk(clk), .rst(rst), .start(start), .size(size), .sgn(sgn),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
    .busy(busy), .done(done), .fault(fault),
    .quotient(quotient), .remainder(remainder)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nchk++; nbad++;
      $display("FAIL watchdog: act=%0d exp=<100000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // wide-integer reference computed from the requirements
  task automatic ref_model(input logic [1:0] s, input bit sg,
                           input logic [63:0] h, input logic [63:0] l,
                           input logic [63:0] d, output bit flt,
                           output logic [63:0] eq, output logic [63:0] er,
                           output int lat);
    int n;
    logic [63:0] m, b, qb, rb;
    logic [127:0] a;
    logic signed [129:0] sa, sb, qs, rs, qa, lim;
    n  = 8 << s;
    m  = 64'hFFFF_FFFF_FFFF_FFFF >> (64 - n);
    if (s == 2'b00) a = {112'd0, l[15:0]};
    else a = ({64'd0, h & m} << n) | {64'd0, l & m};
    b  = d & m;
    sa = $signed({2'b00, a});
    sb = $signed({66'd0, b});
    if (sg) begin
      if (a[2*n-1]) sa = sa - (130'sd1 <<< (2 * n));
      if (b[n-1])   sb = sb - (130'sd1 <<< n);
    end
    eq = '0; er = '0;
    if (b == '0) begin
      flt = 1'b1; lat = 1;
    end else begin
      qs  = sa / sb;
      rs  = sa % sb;
      qa  = (qs < 0) ? -qs : qs;
      lim = 130'sd1 <<< (n - 1);
      lat = (qa >= (130'sd1 <<< n)) ? 1 : n + 1;
      flt = sg ? (qs >= lim || qs < -lim) : (qa >= (130'sd1 <<< n));
      qb  = qs[63:0] & m;
      rb  = rs[63:0] & m;
      if (s == 2'b00) begin eq = {48'd0, rb[7:0], qb[7:0]}; er = '0; end
      else begin eq = qb; er = rb; end
    end
  endtask

  task automatic exec(input logic [1:0] s, input bit sg, input logic [63:0] h,
                      input logic [63:0] l, input logic [63:0] d,
                      input string req, input bit sync, input bit inject);
    bit flt, got;
    logic [63:0] eq, er;
    int lat, cnt;
    if (sync) @(negedge clk);
    size = s; sgn = sg; dvd_hi = h; dvd_lo = l; divisor = d; start = 1'b1;
    ref_model(s, sg, h, l, d, flt, eq, er, lat);
    cnt = 0; got = 1'b0;
    while (!got && cnt < 300) begin
      @(posedge clk); #1;
      cnt++;
      if (cnt == 1) begin
        start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after accept", 64'(busy), 64'd1);
      end
      if (inject && cnt == 3) begin
        dvd_hi = ~h; dvd_lo = ~l; divisor = d + 64'd1; size = ~s; sgn = ~sg;
        start = 1'b1;
      end
      if (inject && cnt == 5) start = 1'b0;
      got = done;
    end
    if (!got) begin
      chk(1'b0, "R7", "done never seen", 64'd0, 64'd1);
      return;
    end
    chk(cnt - 1 == lat, "R7", "latency", 64'(cnt - 1), 64'(lat));
    chk(fault == flt, req, "fault", 64'(fault), 64'(flt));
    if (flt) begin
      chk(quotient == last_q, "R3", "quotient held", quotient, last_q);
      chk(remainder == last_r, "R3", "remainder held", remainder, last_r);
    end else begin
      chk(quotient == eq, req, "quotient", quotient, eq);
      chk(remainder == er, req, "remainder", remainder, er);
      last_q = eq; last_r = er;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fault, "R9", "status after reset",
        {61'd0, busy, done, fault}, 64'd0);
    chk(quotient == '0 && remainder == '0, "R9", "outputs after reset",
        quotient | remainder, 64'd0);
  endtask

  task automatic t_byte;  // R1
    exec(2'b00, 1'b0, 64'hDEAD_BEEF_0000_1111, 64'h0000_0000_0000_03E8, 64'd7, "R1", 1, 0);
    exec(2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hABCD_0000_0000_00FF, 64'hFF00_0000_0000_0010, "R1", 1, 0);
    exec(2'b00, 1'b1, 64'h0, 64'h0000_0000_0000_FF9C, 64'h0000_0000_0000_0007, "R1", 1, 0);
  endtask

  task automatic t_wide;  // R2
    exec(2'b01, 1'b0, 64'hDEAD_0000_0000_0001, 64'hFFFF_0000_0000_0000, 64'h3, "R2", 1, 0);
    exec(2'b10, 1'b0, 64'h1234_5678_0000_0ABC, 64'h0000_0000_DEAD_BEEF, 64'h0001_0000_1000_0003, "R2", 1, 0);
    exec(2'b11, 1'b0, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_000A, "R2", 1, 0);
    exec(2'b11, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h8000_0000_0000_0001, "R2", 1, 0);
  endtask

  task automatic t_zero;  // R3
    exec(2'b10, 1'b0, 64'h0, 64'h100, 64'hFFFF_FFFF_0000_0000, "R3", 1, 0);
    exec(2'b11, 1'b1, 64'h5, 64'h5, 64'h0, "R3", 1, 0);
    exec(2'b00, 1'b0, 64'h0, 64'h1234, 64'hFF00, "R3", 1, 0);
  endtask

  task automatic t_unsigned_limit;  // R4
    exec(2'b01, 1'b0, 64'h4, 64'hFFFF, 64'h5, "R4", 1, 0);
    exec(2'b01, 1'b0, 64'h5, 64'h0, 64'h5, "R4", 1, 0);
    exec(2'b11, 1'b0, 64'h7, 64'h0, 64'h7, "R4", 1, 0);
    exec(2'b00, 1'b0, 64'h0, 64'h0000_0000_0000_FF00, 64'hFF, "R4", 1, 0);
  endtask

  task automatic t_signed;  // R5
    exec(2'b01, 1'b1, 64'hFFFF, 64'hFC18, 64'h7, "R5", 1, 0);
    exec(2'b10, 1'b1, 64'h0, 64'h0000_03E8, 64'hFFFF_FFF9, "R5", 1, 0);
    exec(2'b10, 1'b1, 64'hFFFF_FFFF, 64'hFFFF_FC18, 64'hFFFF_FFF9, "R5", 1, 0);
    exec(2'b11, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64'h3, "R5", 1, 0);
  endtask

  task automatic t_signed_limits;  // R6
    exec(2'b00, 1'b1, 64'h0, 64'hFF80, 64'h01, "R6", 1, 0);
    exec(2'b00, 1'b1, 64'h0, 64'h0080, 64'hFF, "R6", 1, 0);
    exec(2'b00, 1'b1, 64'h0, 64'hFF80, 64'hFF, "R6", 1, 0);
    exec(2'b00, 1'b1, 64'h0, 64'h007F, 64'h01, "R6", 1, 0);
    exec(2'b01, 1'b1, 64'hFFFF, 64'h8000, 64'hFFFF, "R6", 1, 0);
    exec(2'b11, 1'b1, 64'h8000_0000_0000_0000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R6", 1, 0);
    exec(2'b11, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R6", 1, 0);
    exec(2'b11, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h1, "R6", 1, 0);
  endtask

  task automatic t_busy;  // R8
    exec(2'b11, 1'b0, 64'h0000_0000_0000_0003, 64'h1111_2222_3333_4444, 64'h0000_0000_0001_0001, "R8", 1, 1);
    exec(2'b10, 1'b1, 64'h0, 64'h7FFF_FFFF, 64'h3, "R8", 1, 1);
    // back-to-back: next start raised in the done cycle
    exec(2'b01, 1'b0, 64'h0, 64'hFFFF, 64'h10, "R8", 1, 0);
    exec(2'b01, 1'b1, 64'h0, 64'h0064, 64'hFFFD, "R8", 0, 0);
  endtask

  task automatic t_random;  // R2 and R5 across sizes
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 6; i++) begin
        int n;
        logic [63:0] m, h, l, d;
        n = 8 << s;
        m = 64'hFFFF_FFFF_FFFF_FFFF >> (64 - n);
        l = {$urandom, $urandom};
        d = {$urandom, $urandom};
        if (i % 2 == 0) begin
          d = d | (64'd1 << (n - 1));
          h = {$urandom, $urandom} & (m >> 1);
          exec(2'(s), 1'b0, h, l, d, "R2", 1, 0);
        end else begin
          h = l[n-1] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0;
          if (s == 0) l = {l[63:8], {8{l[7]}}} ^ 64'h0000_0000_0000_00FF & l;
          exec(2'(s), 1'b1, h, l, d, "R5", 1, 0);
        end
      end
    end
  endtask

  initial begin
    t_reset();
    t_byte();
    t_wide();
    t_zero();
    t_unsigned_limit();
    t_signed();
    t_signed_limits();
    t_busy();
    t_random();
    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule